// File: doc/BRIEF.md
# Direct-Mapped Hash-Entry Cache

This block is a small on-chip cache placed between the build and probe engines of a hash join and a slow external memory that holds the hash table. Every request carries a hash index. The low bits of the index select one line of a direct-mapped array. The remaining high bits are kept as the line's tag. Each line stores a complete hash-table entry, the tag and a valid bit.

Reads that hit are answered from the array one cycle after they are accepted. Reads that miss are sent to the backing memory, and the answer is returned once memory responds. Whether a miss fills a line depends on the join phase that comes with the request. Only probe-phase misses allocate. Every build-phase write allocates. All writes are also sent on to memory in the cycle they are accepted, so the cache never holds data that memory lacks. Only one miss can be outstanding at a time, and the block takes no new request until that miss is answered.

Top module: `hash_entry_cache`

## Requirements
- R1: After reset no line is valid, `rspValid` is low and both counters read zero, so the first read of any index misses.
- R2: The line is selected by `reqIdx[LINE_BITS-1:0]` and the tag is `reqIdx[IDX_W-1:LINE_BITS]`. A read hits only when the selected line is valid and its stored tag equals the request tag. Two indices that share a line but differ in tag never hit for each other.
- R3: An accepted read that hits raises `rspValid` with `rspHit`=1 and the stored entry on the clock edge after acceptance. It issues no memory request.
- R4: An accepted read that misses raises `memReqValid` with `memReqWrite`=0 and `memReqIdx` equal to the request index in the accepting cycle. On the edge after the cycle in which `memRspValid` is high, `rspValid` rises with `rspHit`=0 and the returned memory data.
- R5: From the acceptance of a read miss until its response appears, `reqReady` stays low.
- R6: `reqPhase`=1 (probe) read misses fill the selected line with the memory data. `reqPhase`=0 (build) read misses leave the array unchanged.
- R7: A `reqPhase`=0 write (`reqWrite`=1) always allocates its line with the written entry, evicting whatever was there.
- R8: A `reqPhase`=1 write updates the line only if it hits. Otherwise the array is unchanged.
- R9: Every accepted write drives `memReqValid` with `memReqWrite`=1 and the request index and data in the accepting cycle. A write produces no response.
- R10: `reqReady` is high only when no miss is pending and `memReqReady` is high.
- R11: `hitCount` and `missCount` each increase by one for every accepted read hit and read miss respectively. Writes change neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Engine request valid |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqPhase | input | 1 | 0 = build phase, 1 = probe phase |
| reqIdx | input | IDX_W | Hash index |
| reqData | input | ENTRY_W | Entry to write |
| rspValid | output | 1 | Read response valid (one-cycle pulse) |
| rspHit | output | 1 | Response was served from the array |
| rspData | output | ENTRY_W | Entry returned |
| memReqValid | output | 1 | Backing-memory request valid |
| memReqReady | input | 1 | Backing memory can take a request |
| memReqWrite | output | 1 | Backing-memory request is a write |
| memReqIdx | output | IDX_W | Backing-memory index |
| memReqData | output | ENTRY_W | Backing-memory write data |
| memRspValid | input | 1 | Backing-memory read data valid |
| memRspData | input | ENTRY_W | Backing-memory read data |
| hitCount | output | CNT_W | Accepted read hits |
| missCount | output | CNT_W | Accepted read misses |

## Verification
A corrupted tag or valid bit appears at the ports on the next read of that line. A wrong hit shows as `rspValid` one cycle after acceptance with stale data and no memory request. A wrong miss shows as a memory read and `rspHit` low. A wrong allocation decision is invisible at write time and only appears on a later read of the same index, so the bench reads back after every phase-specific write or miss. A stuck miss state shows at once as `reqReady` held low after the memory response.

// File: rtl/hec_pkg.sv
package hec_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} hecState_t;

  typedef struct packed {
    logic cacheWr;
    logic fill;
    logic latchMiss;
    logic rspCache;
    logic rspMem;
    logic cntHit;
    logic cntMiss;
  } hecStrobes_t;
endpackage

// File: rtl/hec_ctrl.sv
module hec_ctrl
  import hec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqPhase,
  input  logic        lookupHit,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        memReqWrite,
  output hecStrobes_t strb
);
  hecState_t state;
  logic      fillPhase;
  logic      idle;
  logic      accept;
  logic      readAcc;

  assign idle        = (state == ST_IDLE);
  assign reqReady    = idle && memReqReady;
  assign accept      = reqValid && reqReady;
  assign readAcc     = accept && !reqWrite;
  assign memReqValid = idle && reqValid && (reqWrite || !lookupHit);
  assign memReqWrite = reqWrite;

  always_comb begin
    strb           = '0;
    strb.cacheWr   = accept && reqWrite && (!reqPhase || lookupHit);
    strb.rspCache  = readAcc && lookupHit;
    strb.cntHit    = readAcc && lookupHit;
    strb.latchMiss = readAcc && !lookupHit;
    strb.cntMiss   = readAcc && !lookupHit;
    strb.rspMem    = !idle && memRspValid;
    strb.fill      = !idle && memRspValid && fillPhase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      fillPhase <= 1'b0;
    end else begin
      if (strb.latchMiss) begin
        state     <= ST_WAIT;
        fillPhase <= reqPhase;
      end else if (strb.rspMem) begin
        state     <= ST_IDLE;
      end
    end
  end

  // R5: a pending miss keeps the block busy until memory answers
  p_wait_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !memRspValid) |=> (state == ST_WAIT));

  // R3: a read hit never goes to memory
  p_no_mem_on_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && lookupHit) |-> !memReqValid);
endmodule

// File: rtl/hec_dp.sv
module hec_dp
  import hec_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int LINE_BITS = 3,
  parameter int ENTRY_W   = 32,
  parameter int CNT_W     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  hecStrobes_t        strb,
  input  logic [IDX_W-1:0]   reqIdx,
  input  logic [ENTRY_W-1:0] reqData,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic               lookupHit,
  output logic               rspValid,
  output logic               rspHit,
  output logic [ENTRY_W-1:0] rspData,
  output logic [CNT_W-1:0]   hitCount,
  output logic [CNT_W-1:0]   missCount
);
  localparam int LINES = 1 << LINE_BITS;
  localparam int TAG_W = IDX_W - LINE_BITS;

  logic [LINES-1:0]     lineValid;
  logic [TAG_W-1:0]     lineTag  [LINES];
  logic [ENTRY_W-1:0]   lineData [LINES];

  logic [LINE_BITS-1:0] lineSel;
  logic [TAG_W-1:0]     reqTag;
  logic [LINE_BITS-1:0] missLine;
  logic [TAG_W-1:0]     missTag;

  assign lineSel   = reqIdx[LINE_BITS-1:0];
  assign reqTag    = reqIdx[IDX_W-1:LINE_BITS];
  assign lookupHit = lineValid[lineSel] && (lineTag[lineSel] == reqTag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missLine <= '0;
      missTag  <= '0;
    end else if (strb.latchMiss) begin
      missLine <= lineSel;
      missTag  <= reqTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= '0;
    end else if (strb.cacheWr) begin
      lineValid[lineSel] <= 1'b1;
    end else if (strb.fill) begin
      lineValid[missLine] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.cacheWr) begin
      lineTag[lineSel]  <= reqTag;
      lineData[lineSel] <= reqData;
    end else if (strb.fill) begin
      lineTag[missLine]  <= missTag;
      lineData[missLine] <= memRspData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.rspCache || strb.rspMem;
      rspHit   <= strb.rspCache;
      if (strb.rspCache)    rspData <= lineData[lineSel];
      else if (strb.rspMem) rspData <= memRspData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      if (strb.cntHit)  hitCount  <= hitCount + 1'b1;
      if (strb.cntMiss) missCount <= missCount + 1'b1;
    end
  end

  // R3: hit answered on the next edge, marked as hit
  p_hit_rsp_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.rspCache |=> (rspValid && rspHit));

  // R4: memory data forwarded on the edge after it arrives
  p_mem_rsp_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.rspMem |=> (rspValid && !rspHit && rspData == $past(memRspData)));

  // R7: an allocating write leaves its line valid
  p_alloc_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.cacheWr |=> lineValid[$past(lineSel)]);

  // R11: counters move only on their own events
  p_cnt_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cntHit && !strb.cntMiss) |=> ($stable(hitCount) && $stable(missCount)));
endmodule

// File: rtl/hash_entry_cache.sv
module hash_entry_cache
  import hec_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int LINE_BITS = 3,
  parameter int ENTRY_W   = 32,
  parameter int CNT_W     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic               reqPhase,
  input  logic [IDX_W-1:0]   reqIdx,
  input  logic [ENTRY_W-1:0] reqData,
  output logic               rspValid,
  output logic               rspHit,
  output logic [ENTRY_W-1:0] rspData,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic               memReqWrite,
  output logic [IDX_W-1:0]   memReqIdx,
  output logic [ENTRY_W-1:0] memReqData,
  input  logic               memRspValid,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic [CNT_W-1:0]   hitCount,
  output logic [CNT_W-1:0]   missCount
);
  hecStrobes_t strb;
  logic        lookupHit;

  assign memReqIdx  = reqIdx;
  assign memReqData = reqData;

  hec_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqPhase    (reqPhase),
    .lookupHit   (lookupHit),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite),
    .strb        (strb)
  );

  hec_dp #(
    .IDX_W     (IDX_W),
    .LINE_BITS (LINE_BITS),
    .ENTRY_W   (ENTRY_W),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqIdx     (reqIdx),
    .reqData    (reqData),
    .memRspData (memRspData),
    .lookupHit  (lookupHit),
    .rspValid   (rspValid),
    .rspHit     (rspHit),
    .rspData    (rspData),
    .hitCount   (hitCount),
    .missCount  (missCount)
  );

  // R10: no acceptance while memory cannot take a request
  p_ready_needs_mem_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> memReqReady);
endmodule

// File: tb/tb_hash_entry_cache.sv
`timescale 1ns/100ps
module tb_hash_entry_cache;
  localparam int IDX_W = 8, LINE_BITS = 3, ENTRY_W = 32, CNT_W = 16;
  localparam int LINES = 1 << LINE_BITS;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, reqPhase = 0;
  logic [IDX_W-1:0] reqIdx = '0;
  logic [ENTRY_W-1:0] reqData = '0;
  logic reqReady, rspValid, rspHit, memReqValid, memReqWrite;
  logic [ENTRY_W-1:0] rspData, memReqData;
  logic [IDX_W-1:0] memReqIdx;
  logic memReqReady = 1'b1, memRspValid = 1'b0;
  logic [ENTRY_W-1:0] memRspData = '0;
  logic [CNT_W-1:0] hitCount, missCount;

  always #2 clk = ~clk;

  hash_entry_cache dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqPhase(reqPhase), .reqIdx(reqIdx), .reqData(reqData),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqIdx(memReqIdx), .memReqData(memReqData),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .hitCount(hitCount), .missCount(missCount));

  int checks = 0, fails = 0, cycles = 0;
  int expHits = 0, expMiss = 0;
  int memLat = 32;
  bit randReady = 0;
  logic [ENTRY_W-1:0] backMem [1 << IDX_W];
  bit                 mValid [LINES];
  logic [IDX_W-LINE_BITS-1:0] mTag [LINES];
  logic [ENTRY_W-1:0] mData [LINES];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // backing memory model
  initial begin
    bit pend = 0;
    int cnt = 0;
    logic [IDX_W-1:0] pIdx = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          memRspValid = 1'b1;
          memRspData  = backMem[pIdx];
          pend = 0;
        end else cnt--;
      end
      memReqReady = randReady ? (($urandom % 4) != 0) : 1'b1;
      #1;
      if (rstN && memReqValid && memReqReady) begin
        if (memReqWrite) backMem[memReqIdx] = memReqData;
        else begin
          pend = 1; cnt = memLat; pIdx = memReqIdx;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic doOp(input bit wr, input bit ph, input logic [IDX_W-1:0] idx,
                      input logic [ENTRY_W-1:0] d);
    int wd;
    bit expHit, got, mv;
    logic [LINE_BITS-1:0] ln;
    logic [IDX_W-LINE_BITS-1:0] tg;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqPhase = ph; reqIdx = idx; reqData = d;
    #1;
    wd = 0;
    while (!reqReady && wd < 1000) begin @(negedge clk); #1; wd++; end
    check(memReqReady, "R10", "ready without memory ready", memReqReady, 1);
    ln = idx[LINE_BITS-1:0]; tg = idx[IDX_W-1:LINE_BITS];
    expHit = mValid[ln] && (mTag[ln] == tg);
    if (wr) begin
      check(memReqValid && memReqWrite && memReqIdx == idx && memReqData == d,
            "R9", "write-through request", {memReqValid, memReqWrite, memReqIdx}, {2'b11, idx});
    end else if (!expHit) begin
      check(memReqValid && !memReqWrite && memReqIdx == idx,
            "R4", "miss read request", {memReqValid, memReqWrite, memReqIdx}, {2'b10, idx});
    end else begin
      check(!memReqValid, "R3", "hit issued memory request", memReqValid, 0);
    end
    @(posedge clk); #1;
    reqValid = 0;
    if (wr) begin
      check(!rspValid, "R9", "write produced response", rspValid, 0);
      if (!ph || expHit) begin  // R7 build allocates, R8 probe only on hit
        mValid[ln] = 1; mTag[ln] = tg; mData[ln] = d;
      end
    end else if (expHit) begin
      expHits++;
      check(rspValid && rspHit && rspData == mData[ln], "R3", "hit response",
            rspData, mData[ln]);
    end else begin
      expMiss++;
      check(!rspValid, "R4", "early miss response", rspValid, 0);
      got = 0;
      for (int k = 0; k < 2000 && !got; k++) begin
        @(negedge clk); #1;
        mv = memRspValid;
        if (reqReady) check(0, "R5", "ready during pending miss", reqReady, 0);
        @(posedge clk); #1;
        if (mv) begin
          got = 1;
          check(rspValid && !rspHit && rspData == backMem[idx], "R4", "miss response",
                rspData, backMem[idx]);
          if (ph) begin  // R6 probe miss fills
            mValid[ln] = 1; mTag[ln] = tg; mData[ln] = backMem[idx];
          end
        end else if (rspValid) check(0, "R4", "response before memory data", rspValid, 0);
      end
      if (!got) check(0, "R4", "no memory response", 0, 1);
    end
    check(hitCount == expHits[CNT_W-1:0] && missCount == expMiss[CNT_W-1:0], "R11",
          "counters", {hitCount, missCount}, {expHits[15:0], expMiss[15:0]});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1 << IDX_W); i++) backMem[i] = (i * 32'h01010101) ^ 32'hA5000000;
    for (int i = 0; i < LINES; i++) begin mValid[i] = 0; mTag[i] = '0; mData[i] = '0; end
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    check(!rspValid && hitCount == 0 && missCount == 0 && !memReqValid, "R1", "reset state",
          {rspValid, hitCount[14:0], missCount}, 0);

    doOp(0, 1, 8'h05, '0);                 // R1 first read misses
    doOp(0, 0, 8'h11, '0);                 // R6 build miss
    doOp(0, 0, 8'h11, '0);                 // R6 still misses (no allocate)
    doOp(0, 1, 8'h11, '0);                 // R6 probe miss fills
    doOp(0, 1, 8'h11, '0);                 // R3 hit
    doOp(0, 1, 8'h19, '0);                 // R2 alias on line 1 misses, evicts
    doOp(0, 0, 8'h11, '0);                 // R2 original now misses
    doOp(1, 0, 8'h22, 32'hCAFE0022);       // R7 build write allocates
    doOp(0, 1, 8'h22, '0);                 // R7 hit with written data
    doOp(1, 0, 8'h2A, 32'hBEEF002A);       // R7 evicts line 2
    doOp(0, 0, 8'h22, '0);                 // R9 miss returns written-through data
    doOp(1, 1, 8'h33, 32'h0D0D0033);       // R8 probe write, not resident
    doOp(0, 0, 8'h33, '0);                 // R8 no alloc, R9 memory updated
    doOp(0, 1, 8'h44, '0);                 // fill line 4
    doOp(1, 1, 8'h44, 32'h12340044);       // R8 probe write hit updates
    doOp(0, 0, 8'h44, '0);                 // R8 hit with new data
    memLat = 0;
    doOp(0, 1, 8'h57, '0);                 // R4 zero-latency memory

    randReady = 1;
    for (int n = 0; n < 250; n++) begin
      logic [IDX_W-1:0] ri;
      ri = {3'b0, 2'($urandom % 4), 3'($urandom % 8)};
      memLat = (($urandom % 3) == 0) ? 32 : int'($urandom % 12);
      doOp(($urandom % 3) == 0, $urandom % 2, ri, $urandom);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule